// File: doc/BRIEF.md
# Interval Timebase Timer with Interrupt

This block is a free-running prescaler that raises an interrupt request each time a chosen power-of-two number of input clocks has gone by. It counts every clock from hardware reset and never stops. A 3-bit select picks one of eight counter taps. Each time the chosen tap wraps, a sticky request flag is set. The request line is driven while both the flag and an enable bit are 1.

Software reaches the block through one byte-wide control register on a simple synchronous bus with an address, a write enable, write data and registered read data. The flag is cleared by writing 0 to it, and writing 1 to it does nothing. There are two reset inputs. The hardware reset clears everything. The software reset clears only the flag and the enable, and the interval choice and the two spare bits survive it.

Top module: `interval_timer`

## Requirements
- R1: The register decodes at address REG_ADDR (default 16'h0482). It reads as {flag[7], enable[6], select[5:3], 0[2], spare[1:0]}. `rdata` is registered: in the cycle after an address is presented, it shows the register as it stood before that edge.
- R2: Select code c gives a period of 2^(LO_EXP+c) clocks for c = 0..2, and 2^(HI_EXP+c-3) clocks for c = 3..7. The defaults are LO_EXP = 11 and HI_EXP = 22, which give 2^11, 2^12, 2^13 and 2^22 to 2^26.
- R3: The counter starts at 0 on hardware reset and adds one on every clock. The flag is set on the edge at which the count becomes a multiple of the selected period.
- R4: A write to the register with bit 7 = 0 clears the flag. A write with bit 7 = 1 leaves the flag unchanged.
- R5: When an interval event and a clearing write fall on the same edge, the flag ends at 1.
- R6: `irq` is 1 exactly when flag and enable are both 1. It changes on the same edge as those bits.
- R7: Writes to bit 2 are ignored and bit 2 always reads 0. Reads from any other address return 0, and writes to any other address change nothing.
- R8: While `rst` is high, flag, enable, select, spare bits, counter, `irq` and `rdata` all go to 0.
- R9: `srst` clears the flag and the enable. It keeps the select, the spare bits and the counter. It wins over an interval event and over a write on the same edge.
- R10: A change of select does not touch the counter. The next event comes at the next multiple of the newly selected period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| srst | input | 1 | Synchronous software reset, active high |
| we | input | 1 | Write strobe for the bus |
| addr | input | ADDR_W | Bus address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request, registered |

## Verification
The bench times stimulus from its own model count so that a clearing write lands on the exact edge of an interval event. A design that let the clear win would drop that interval, and the flag would read 0. It fires a software reset together with an event and with a write that changes the select. A wrong priority would leave the flag set, or would let the select change when it should be held. Select changes in the middle of a period check that the counter is not restarted; a design that restarted it would move the next event later. Writes to other addresses and to bit 2 would show up as changed read data if they were wrongly accepted.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

  localparam int FLAG_POS = 7;
  localparam int EN_POS   = 6;
  localparam int SEL_LSB  = 3;

  typedef struct packed {
    logic       flag;
    logic       en;
    logic [2:0] sel;
    logic [1:0] spare;
  } ctl_t;

  // exponent of the period picked by a select code
  function automatic int tap_exp(input int code, input int lo, input int hi);
    return (code < 3) ? (lo + code) : (hi + code - 3);
  endfunction

endpackage

// File: rtl/itmr_counter.sv
module itmr_counter #(
  parameter int CNT_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/itmr_tap.sv
module itmr_tap
  import itmr_pkg::*;
#(
  parameter int LO_EXP = 11,
  parameter int HI_EXP = 22,
  parameter int CNT_W  = HI_EXP + 4
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [2:0]       sel,
  output logic             evt
);

  localparam int NCODE = 8;

  logic [NCODE-1:0] wrap;

  // tap wraps on the next edge when all bits below and at it are ones
  for (genvar c = 0; c < NCODE; c++) begin : g_tap
    localparam int E = tap_exp(c, LO_EXP, HI_EXP);
    assign wrap[c] = &cnt[E-1:0];
  end

  assign evt = wrap[sel];

endmodule

// File: rtl/itmr_regs.sv
module itmr_regs
  import itmr_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0482
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              srst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              evt,
  output ctl_t              ctl,
  output logic              irq,
  output logic [7:0]        rdata
);

  logic sel_hit;
  logic wr_hit;
  ctl_t nxt;

  assign sel_hit = (addr == REG_ADDR);
  assign wr_hit  = we && sel_hit && !srst;

  always_comb begin
    nxt = ctl;
    if (srst) begin
      nxt.flag = 1'b0;
      nxt.en   = 1'b0;
    end else begin
      if (evt)                             nxt.flag = 1'b1;
      else if (wr_hit && !wdata[FLAG_POS]) nxt.flag = 1'b0;
      if (wr_hit) begin
        nxt.en    = wdata[EN_POS];
        nxt.sel   = wdata[SEL_LSB+2:SEL_LSB];
        nxt.spare = wdata[1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl   <= '0;
      irq   <= 1'b0;
      rdata <= '0;
    end else begin
      ctl   <= nxt;
      irq   <= nxt.flag & nxt.en;
      rdata <= sel_hit ? {ctl.flag, ctl.en, ctl.sel, 1'b0, ctl.spare} : 8'h00;
    end
  end

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0482,
  parameter int                LO_EXP   = 11,
  parameter int                HI_EXP   = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              srst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              irq
);

  localparam int CNT_W = HI_EXP + 4;

  logic [CNT_W-1:0] cnt_q;
  logic             evt;
  ctl_t             ctl_q;

  itmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .cnt (cnt_q)
  );

  itmr_tap #(.LO_EXP(LO_EXP), .HI_EXP(HI_EXP), .CNT_W(CNT_W)) u_tap (
    .cnt (cnt_q),
    .sel (ctl_q.sel),
    .evt (evt)
  );

  itmr_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .srst  (srst),
    .we    (we),
    .addr  (addr),
    .wdata (wdata),
    .evt   (evt),
    .ctl   (ctl_q),
    .irq   (irq),
    .rdata (rdata)
  );

endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int                CNT_W    = 26,
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0482
) (
  input logic              clk,
  input logic              rst,
  input logic              srst,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic              irq,
  input logic              flag,
  input logic              en,
  input logic [2:0]        sel,
  input logic [CNT_W-1:0]  cnt
);

  // R6
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (flag && en));

  // R8
  hw_reset_chk: assert property (@(posedge clk)
    rst |=> (rdata == 8'h00 && !irq && !flag && !en && sel == 3'd0 && cnt == '0));

  // R9
  soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
    srst |=> (!flag && !en && $stable(sel)));

  // R4
  set_write_chk: assert property (@(posedge clk) disable iff (rst)
    (we && addr == REG_ADDR && wdata[7] && !srst && flag) |=> flag);

  // R7
  bit2_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rdata[2] == 1'b0);

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> cnt == CNT_W'($past(cnt) + 1'b1));

endmodule

bind interval_timer interval_timer_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .srst(srst), .we(we), .addr(addr), .wdata(wdata),
  .rdata(rdata), .irq(irq), .flag(ctl_q.flag), .en(ctl_q.en),
  .sel(ctl_q.sel), .cnt(cnt_q)
);

// File: tb/interval_timer_test.sv
module interval_timer_test;

  localparam int          LO   = 3;
  localparam int          HI   = 6;
  localparam int          CW   = HI + 4;
  localparam logic [15:0] RADR = 16'h0482;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        srst = 1'b0;
  logic        we = 1'b0;
  logic [15:0] addr = RADR;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        irq;

  interval_timer #(.ADDR_W(16), .REG_ADDR(RADR), .LO_EXP(LO), .HI_EXP(HI)) uut (
    .clk(clk), .rst(rst), .srst(srst), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  // behavioural reference
  int m_cnt = 0, m_flag = 0, m_en = 0, m_sel = 0, m_spare = 0;
  int m_rd = 0, m_irq = 0;
  int checks = 0, fails = 0;
  string cur_req = "R8";
  bit done = 0;

  function automatic int period(input int s);
    return 1 << ((s < 3) ? (LO + s) : (HI + s - 3));
  endfunction

  function automatic bit next_evt();
    return ((m_cnt + 1) % period(m_sel)) == 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_flag = 0; m_en = 0; m_sel = 0; m_spare = 0; m_rd = 0; m_irq = 0;
    end else begin
      bit ev, hit;
      ev  = next_evt();
      hit = we && (addr == RADR) && !srst;
      m_rd = (addr == RADR) ? ((m_flag << 7) | (m_en << 6) | (m_sel << 3) | m_spare) : 0;
      if (srst) begin
        m_flag = 0; m_en = 0;
      end else begin
        if (ev) m_flag = 1;
        else if (hit && !wdata[7]) m_flag = 0;
        if (hit) begin
          m_en = wdata[6]; m_sel = wdata[5:3]; m_spare = wdata[1:0];
        end
      end
      m_cnt = (m_cnt + 1) % (1 << CW);
      m_irq = m_flag & m_en;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (rdata !== 8'(m_rd)) begin
        fails++;
        $display("FAIL %s rdata got %h exp %h", cur_req, rdata, 8'(m_rd));
      end
      checks++;
      if (irq !== 1'(m_irq)) begin
        fails++;
        $display("FAIL %s irq got %b exp %b", cur_req, irq, 1'(m_irq));
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = RADR;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_evt();
    do @(negedge clk); while (!next_evt());
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R8: hardware reset state
    cur_req = "R8";
    idle(4);
    rst = 1'b0;
    idle(3);

    // R1 and R7: layout, bit 2 ignored
    cur_req = "R1";
    wr(RADR, 8'b1_1_010_1_11);
    idle(3);

    // R2 and R3: every select code, flag raised each period
    cur_req = "R2";
    for (int s = 0; s < 8; s++) begin
      wr(RADR, 8'h40 | 8'(s << 3));
      idle(2 * period(s) + 3);
      cur_req = "R3";
      wr(RADR, 8'h40 | 8'(s << 3));
      cur_req = "R2";
    end

    // R4: writing 1 keeps flag, writing 0 clears
    cur_req = "R4";
    wr(RADR, 8'h40);
    wait_evt();
    idle(2);
    wr(RADR, 8'hC0);
    idle(2);
    wr(RADR, 8'h40);
    idle(2);

    // R6: disabling enable drops irq while flag stays set
    cur_req = "R6";
    wait_evt();
    idle(2);
    wr(RADR, 8'h80);
    idle(3);
    wr(RADR, 8'hC0);
    idle(3);

    // R5: clear on the event edge, set wins
    cur_req = "R5";
    wr(RADR, 8'h48);
    wait_evt();
    we = 1'b1; addr = RADR; wdata = 8'h48;
    @(negedge clk);
    we = 1'b0;
    idle(3);

    // R9: soft reset keeps select/spare/counter, beats event and write
    cur_req = "R9";
    wr(RADR, 8'b0_1_001_0_10);
    wait_evt();
    srst = 1'b1; we = 1'b1; wdata = 8'b0_1_111_0_01;
    @(negedge clk);
    srst = 1'b0; we = 1'b0;
    idle(3);
    wait_evt();
    idle(3);

    // R7: unmapped address write and read
    cur_req = "R7";
    wr(16'h0483, 8'hFF);
    addr = 16'h0100;
    idle(3);
    addr = RADR;
    idle(3);

    // R10: select change mid-period, no counter restart
    cur_req = "R10";
    wr(RADR, 8'h58);
    idle(5);
    wr(RADR, 8'h40);
    idle(40);
    wr(RADR, 8'h50);
    idle(20);
    wr(RADR, 8'h60);
    idle(300);

    // R8: reset again from a busy state
    cur_req = "R8";
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    idle(10);

    finish_run();
  end

endmodule